// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a virtual word address into a physical word address for a memory system in which every segment is itself divided into pages. A request carries a 34-bit virtual address and an access kind. The virtual address holds an 18-bit segment number, a 6-bit page number and a 10-bit word offset. The block walks two tables through a single memory read port. First it reads the segment descriptor that sits at the descriptor table base plus the segment number. Then, if the segment is present and the access is allowed, it reads the page entry that sits at the segment's page table base plus the page number. It answers with one status code and, on success, the page origin plus the offset.

The control is a six-state machine. The states are `ST_IDLE` (waiting, ready high), `ST_DESC_REQ` (strobe the descriptor read), `ST_DESC_WAIT` (wait for descriptor data and judge it), `ST_PTE_REQ` (strobe the page entry read), `ST_PTE_WAIT` (wait for page entry data and form the result) and `ST_REPLY` (present the response for one cycle). The transitions are: *accept* (`ST_IDLE` to `ST_DESC_REQ` on a valid request), *desc_issue* (`ST_DESC_REQ` to `ST_DESC_WAIT`), *desc_fault* (`ST_DESC_WAIT` to `ST_REPLY` when the descriptor raises a fault), *desc_pass* (`ST_DESC_WAIT` to `ST_PTE_REQ`), *pte_issue* (`ST_PTE_REQ` to `ST_PTE_WAIT`), *pte_done* (`ST_PTE_WAIT` to `ST_REPLY` when data returns) and *reply_done* (`ST_REPLY` to `ST_IDLE`).

Loading missing segments or pages from backing storage is left to software. The block does not cache translations.

Top module: `seg_page_xlate`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a walk is in progress, `req_valid` has no effect, and exactly one response follows each accepted request.
- R2: After acceptance the block issues one read at `desc_base + segment` (modulo 2^24). The segment number is virtual address bits 33:16, the page number is bits 15:10 and the offset is bits 9:0.
- R3: A descriptor with bit 35 (present) clear gives status 1 (segment missing). No page entry read is issued, and the response comes 2 cycles after the accepting edge when memory answers one cycle after each read strobe.
- R4: Access kind 0 (read) needs descriptor bit 34. Kind 1 (write) needs bit 33. Kind 2 (execute) needs bit 32. Kind 3 is always refused. A refused access gives status 2 (protection), 2 cycles after acceptance.
- R5: A page number greater than or equal to the descriptor's length field (bits 30:24, 0 to 64 pages) gives status 3 (bounds), 2 cycles after acceptance.
- R6: Only one status is reported, chosen in this priority: segment missing, then protection, then bounds, then page missing.
- R7: For a descriptor that passes, the page entry is read at the page table base (descriptor bits 23:0) plus the page number. A page entry with bit 35 clear gives status 4 (page missing), 4 cycles after acceptance.
- R8: A present page entry gives status 0 and `rsp_paddr` = page origin (entry bits 23:0) + offset, modulo 2^24, 4 cycles after acceptance.
- R9: `rsp_valid` is a single-cycle pulse, and `rsp_paddr` is zero whenever the status is non-zero.
- R10: During and right after reset, `req_ready` is 1, and `rsp_valid` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_base | input | 24 | Word address of the descriptor table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 34 | Virtual word address {segment, page, offset} |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 invalid |
| mem_rd_en | output | 1 | One-cycle read strobe |
| mem_rd_addr | output | 24 | Read word address |
| mem_rd_valid | input | 1 | Read data is present this cycle |
| mem_rd_data | input | 36 | Read data word |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 3 | 0 ok, 1 segment missing, 2 protection, 3 bounds, 4 page missing |
| rsp_paddr | output | 24 | Physical word address, zero on any fault |

## Verification
The bench memory returns data in the cycle after each read strobe. With that memory, every fault found in the descriptor is due 2 clock edges after the accepting edge, and a page-missing or successful result is due 4 edges after it. The driver records the cycle of acceptance with each expected item in the scoreboard. The monitor samples on falling edges and compares the status, the address and the elapsed cycle count for every response. Any response that arrives while the queue is empty is reported, and this is how a request taken in error during a busy walk is caught.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [2:0] {
        XS_OK        = 3'd0,
        XS_SEG_MISS  = 3'd1,
        XS_PROT      = 3'd2,
        XS_BOUNDS    = 3'd3,
        XS_PAGE_MISS = 3'd4
    } xl_status_e;

    typedef enum logic [1:0] {
        AK_READ  = 2'd0,
        AK_WRITE = 2'd1,
        AK_EXEC  = 2'd2,
        AK_BAD   = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_WAIT,
        ST_PTE_REQ,
        ST_PTE_WAIT,
        ST_REPLY
    } walk_state_e;

endpackage

// File: rtl/xlate_addr_gen.sv
module xlate_addr_gen #(
    parameter int SEG_W = 18,
    parameter int PG_W  = 6,
    parameter int PA_W  = 24
) (
    input  logic [PA_W-1:0]  tbl_base,
    input  logic [SEG_W-1:0] seg_num,
    input  logic [PA_W-1:0]  pt_base,
    input  logic [PG_W-1:0]  page_num,
    input  logic             pick_pte,
    output logic [PA_W-1:0]  rd_addr
);

    logic [PA_W-1:0] desc_addr;
    logic [PA_W-1:0] pte_addr;

    always_comb begin
        desc_addr = tbl_base + PA_W'(seg_num);
        pte_addr  = pt_base + PA_W'(page_num);
        rd_addr   = pick_pte ? pte_addr : desc_addr;
    end

endmodule

// File: rtl/xlate_check.sv
module xlate_check
    import xlate_pkg::*;
#(
    parameter int PG_W  = 6,
    parameter int LEN_W = PG_W + 1
) (
    input  logic             seg_present,
    input  logic             may_read,
    input  logic             may_write,
    input  logic             may_exec,
    input  logic [LEN_W-1:0] seg_len,
    input  logic [PG_W-1:0]  page_num,
    input  logic [1:0]       kind,
    output xl_status_e       verdict
);

    logic allowed;
    logic out_of_range;

    always_comb begin
        unique case (acc_kind_e'(kind))
            AK_READ:  allowed = may_read;
            AK_WRITE: allowed = may_write;
            AK_EXEC:  allowed = may_exec;
            default:  allowed = 1'b0;
        endcase
        out_of_range = LEN_W'(page_num) >= seg_len;

        if (!seg_present) begin
            verdict = XS_SEG_MISS;
        end else if (!allowed) begin
            verdict = XS_PROT;
        end else if (out_of_range) begin
            verdict = XS_BOUNDS;
        end else begin
            verdict = XS_OK;
        end
    end

endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
    import xlate_pkg::*;
#(
    parameter int SEG_W = 18,
    parameter int PG_W  = 6,
    parameter int OFF_W = 10,
    parameter int PA_W  = 24,
    parameter int DW    = 36
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PA_W-1:0]             desc_base,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [SEG_W+PG_W+OFF_W-1:0] req_vaddr,
    input  logic [1:0]                  req_kind,
    output logic                        mem_rd_en,
    output logic [PA_W-1:0]             mem_rd_addr,
    input  logic                        mem_rd_valid,
    input  logic [DW-1:0]               mem_rd_data,
    output logic                        rsp_valid,
    output logic [2:0]                  rsp_status,
    output logic [PA_W-1:0]             rsp_paddr
);

    localparam int VA_W     = SEG_W + PG_W + OFF_W;
    localparam int LEN_W    = PG_W + 1;
    localparam int PG_LSB   = OFF_W;
    localparam int SEG_LSB  = OFF_W + PG_W;
    localparam int BIT_PRES = DW - 1;
    localparam int BIT_R    = DW - 2;
    localparam int BIT_W    = DW - 3;
    localparam int BIT_X    = DW - 4;
    localparam int LEN_LSB  = PA_W;
    localparam int LEN_MSB  = PA_W + LEN_W - 1;
    localparam int DRSV_MSB = DW - 5;
    localparam int PRSV_MSB = DW - 2;

    walk_state_e state_q, state_d;

    logic [VA_W-1:0]  vaddr_q;
    logic [1:0]       kind_q;
    logic [PA_W-1:0]  ptbase_q;
    xl_status_e       status_q;
    logic [PA_W-1:0]  paddr_q;

    logic [SEG_W-1:0] seg_f;
    logic [PG_W-1:0]  page_f;
    logic [OFF_W-1:0] off_f;
    xl_status_e       desc_verdict;
    logic             accept;

    assign seg_f  = vaddr_q[VA_W-1:SEG_LSB];
    assign page_f = vaddr_q[SEG_LSB-1:PG_LSB];
    assign off_f  = vaddr_q[OFF_W-1:0];
    assign accept = req_valid && req_ready;

    xlate_addr_gen #(
        .SEG_W (SEG_W),
        .PG_W  (PG_W),
        .PA_W  (PA_W)
    ) addr_gen_i (
        .tbl_base (desc_base),
        .seg_num  (seg_f),
        .pt_base  (ptbase_q),
        .page_num (page_f),
        .pick_pte (state_q == ST_PTE_REQ),
        .rd_addr  (mem_rd_addr)
    );

    xlate_check #(
        .PG_W  (PG_W),
        .LEN_W (LEN_W)
    ) check_i (
        .seg_present (mem_rd_data[BIT_PRES]),
        .may_read    (mem_rd_data[BIT_R]),
        .may_write   (mem_rd_data[BIT_W]),
        .may_exec    (mem_rd_data[BIT_X]),
        .seg_len     (mem_rd_data[LEN_MSB:LEN_LSB]),
        .page_num    (page_f),
        .kind        (kind_q),
        .verdict     (desc_verdict)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_DESC_REQ;
            ST_DESC_REQ:  state_d = ST_DESC_WAIT;
            ST_DESC_WAIT: begin
                if (mem_rd_valid) begin
                    state_d = (desc_verdict != XS_OK) ? ST_REPLY : ST_PTE_REQ;
                end
            end
            ST_PTE_REQ:   state_d = ST_PTE_WAIT;
            ST_PTE_WAIT:  if (mem_rd_valid) state_d = ST_REPLY;
            ST_REPLY:     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // walk datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q  <= '0;
            kind_q   <= '0;
            ptbase_q <= '0;
            status_q <= XS_OK;
            paddr_q  <= '0;
        end else begin
            if (accept) begin
                vaddr_q <= req_vaddr;
                kind_q  <= req_kind;
            end
            if (state_q == ST_DESC_WAIT && mem_rd_valid) begin
                ptbase_q <= mem_rd_data[PA_W-1:0];
                status_q <= desc_verdict;
                paddr_q  <= '0;
            end
            if (state_q == ST_PTE_WAIT && mem_rd_valid) begin
                if (mem_rd_data[BIT_PRES]) begin
                    status_q <= XS_OK;
                    paddr_q  <= mem_rd_data[PA_W-1:0] + PA_W'(off_f);
                end else begin
                    status_q <= XS_PAGE_MISS;
                    paddr_q  <= '0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_rd_en  = (state_q == ST_DESC_REQ) || (state_q == ST_PTE_REQ);
        rsp_valid  = (state_q == ST_REPLY);
        rsp_status = status_q;
        rsp_paddr  = paddr_q;
    end

    // R1
    taken_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R1
    read_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready);

    // R2
    accept_starts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> mem_rd_en);

    // R3
    seg_miss_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DESC_WAIT && mem_rd_valid && !mem_rd_data[BIT_PRES])
        |=> (rsp_valid && rsp_status == 3'd1 && !mem_rd_en));

    // R9
    reply_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 3'd0) |-> (rsp_paddr == '0));

    // R2
    desc_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DESC_WAIT && mem_rd_valid) |-> (mem_rd_data[DRSV_MSB:LEN_MSB+1] == '0));

    // R7
    pte_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PTE_WAIT && mem_rd_valid) |-> (mem_rd_data[PRSV_MSB:PA_W] == '0));

endmodule

// File: tb/seg_page_xlate_tb.sv
`timescale 1ns/1ps
module seg_page_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] desc_base = 24'h000100;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [33:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        mem_rd_en;
    logic [23:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [35:0] mem_rd_data;
    logic        rsp_valid;
    logic [2:0]  rsp_status;
    logic [23:0] rsp_paddr;

    always #2.5 clk = ~clk;

    seg_page_xlate dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_base    (desc_base),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .req_kind     (req_kind),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .rsp_valid    (rsp_valid),
        .rsp_status   (rsp_status),
        .rsp_paddr    (rsp_paddr)
    );

    logic [35:0] mem [0:4095];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rd_valid <= 1'b0;
            mem_rd_data  <= '0;
        end else begin
            mem_rd_valid <= mem_rd_en;
            mem_rd_data  <= mem[mem_rd_addr[11:0]];
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [2:0]  st;
        logic [23:0] pa;
        int          lat;
        int          acc;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1", "response with no accepted request", 32'(rsp_status), 32'hFFFF);
            end else begin
                e = exp_q.pop_front();
                chk(rsp_status == e.st, e.tag, "status", 32'(rsp_status), 32'(e.st));
                chk(rsp_paddr == e.pa, e.tag, "paddr", 32'(rsp_paddr), 32'(e.pa));
                chk((cyc - e.acc) == e.lat, e.tag, "latency", 32'(cyc - e.acc), 32'(e.lat));
            end
        end
    end

    function automatic logic [35:0] mk_desc(input bit p, input bit r, input bit w,
                                           input bit x, input logic [6:0] len,
                                           input logic [23:0] base);
        return {p, r, w, x, 1'b0, len, base};
    endfunction

    function automatic logic [35:0] mk_pte(input bit p, input logic [23:0] org);
        return {p, 11'b0, org};
    endfunction

    task automatic send(input logic [17:0] seg, input logic [5:0] pg, input logic [9:0] off,
                        input logic [1:0] kind, input logic [2:0] st, input logic [23:0] pa,
                        input string tag, input bit spam);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_vaddr = {seg, pg, off};
        req_kind  = kind;
        req_valid = 1'b1;
        @(negedge clk);
        e.st  = st;
        e.pa  = pa;
        e.lat = (st == 3'd0 || st == 3'd4) ? 4 : 2;
        e.acc = cyc;
        e.tag = tag;
        exp_q.push_back(e);
        if (spam) begin
            req_vaddr = ~req_vaddr;
            req_kind  = 2'd0;
            for (int i = 0; i < 2; i++) begin
                chk(req_ready == 1'b0, "R1", "ready while busy", 32'(req_ready), 32'd0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        // descriptors at desc_base + segment
        mem[12'h101] = mk_desc(1, 1, 1, 0, 7'd8,  24'h000400);
        mem[12'h102] = mk_desc(0, 0, 0, 0, 7'd0,  24'h000000);
        mem[12'h103] = mk_desc(1, 1, 0, 1, 7'd64, 24'h000500);
        mem[12'h105] = mk_desc(1, 0, 1, 0, 7'd0,  24'h000600);
        mem[12'h0FF] = mk_desc(1, 1, 1, 1, 7'd2,  24'h000700);
        // page tables
        mem[12'h400] = mk_pte(1, 24'h123C00);
        mem[12'h403] = mk_pte(1, 24'h0003F0);
        mem[12'h407] = mk_pte(1, 24'hFFFFF0);
        mem[12'h405] = mk_pte(0, 24'h000000);
        mem[12'h409] = mk_pte(0, 24'h000000);
        mem[12'h53F] = mk_pte(1, 24'h040000);
        mem[12'h501] = mk_pte(0, 24'h000000);
        mem[12'h701] = mk_pte(1, 24'h200000);

        repeat (3) @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10", "ready in reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        chk(mem_rd_en == 1'b0, "R10", "mem_rd_en in reset", 32'(mem_rd_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", 32'(rsp_valid), 32'd0);

        // R8 / R2 successful walks
        send(18'd1, 6'd0,  10'h005, 2'd0, 3'd0, 24'h123C05, "R8", 0);
        send(18'd1, 6'd3,  10'h020, 2'd1, 3'd0, 24'h000410, "R8", 0);
        send(18'd1, 6'd7,  10'h3FF, 2'd0, 3'd0, 24'h0003EF, "R8", 0);
        send(18'd3, 6'd63, 10'h100, 2'd2, 3'd0, 24'h040100, "R5", 0);
        send(18'h3FFFF, 6'd1, 10'h007, 2'd2, 3'd0, 24'h200007, "R2", 0);
        // R3 segment missing
        send(18'd2, 6'd0,  10'h000, 2'd0, 3'd1, 24'h0, "R3", 0);
        send(18'd2, 6'd9,  10'h000, 2'd3, 3'd1, 24'h0, "R6", 0);
        // R4 protection
        send(18'd1, 6'd0,  10'h000, 2'd2, 3'd2, 24'h0, "R4", 0);
        send(18'd3, 6'd63, 10'h000, 2'd1, 3'd2, 24'h0, "R4", 0);
        send(18'd1, 6'd0,  10'h000, 2'd3, 3'd2, 24'h0, "R4", 0);
        send(18'd5, 6'd0,  10'h000, 2'd0, 3'd2, 24'h0, "R4", 0);
        // R5 bounds
        send(18'd1, 6'd8,  10'h000, 2'd0, 3'd3, 24'h0, "R5", 0);
        send(18'd5, 6'd0,  10'h000, 2'd1, 3'd3, 24'h0, "R5", 0);
        // R6 priority
        send(18'd1, 6'd8,  10'h000, 2'd2, 3'd2, 24'h0, "R6", 0);
        send(18'd1, 6'd9,  10'h000, 2'd0, 3'd3, 24'h0, "R6", 0);
        // R7 page missing
        send(18'd1, 6'd5,  10'h011, 2'd0, 3'd4, 24'h0, "R7", 0);
        send(18'd3, 6'd1,  10'h000, 2'd0, 3'd4, 24'h0, "R7", 0);
        // R1 requests during a walk are ignored
        send(18'd1, 6'd0,  10'h3FF, 2'd0, 3'd0, 24'h123FFF, "R1", 1);
        send(18'd1, 6'd3,  10'h001, 2'd1, 3'd0, 24'h0003F1, "R9", 0);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "pending responses", 32'(exp_q.size()), 32'd0);
        chk(req_ready == 1'b1, "R1", "idle at end", 32'(req_ready), 32'd1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule